// File: doc/BRIEF.md
# PCI Bus Master Preemption Sequencer

This block is the master half of a 32-bit PCI attachment. An internal DMA engine hands it one job at a time. A job is a count of transfers plus a mode bit. The block then requests the bus, runs the bus phases on FRAME and IRDY, and reacts to the grant, device-select, target-ready and stop lines. The address and data path, parity, configuration decoding and the arbiter all sit outside it.

There are two modes. In single-phase mode the job is a train of transactions, each with one data phase, and the block gives up the bus as soon as the grant is withdrawn. In burst mode the job is a run of data phases. Only one transaction is made per bus tenure, and a loss of grant is ignored until a latency counter has run out. When preempted, the block finishes two more data phases, releases the bus and keeps its request asserted so the remaining words go out in the next tenure.

A target abort and a missing device-select are reported in status flags, which the host clears by writing ones. A target abort also raises a system-interrupt flag, and that flag drives a maskable interrupt output.

Top module: `pcim_preempt_seq`

## Requirements
- R1: After reset, `breq_n`, `frm_n`, `ird_n` and `int_n` are high, `job_busy` is low and all three status flags are clear.
- R2: A job is accepted on an edge where `job_start` is high, `job_len` is nonzero and `job_busy` is low. A start while busy has no effect: the running job moves exactly its own word count and produces exactly one `job_done`.
- R3: `breq_n` goes low when a job is accepted. While more than one item of the job remains, it stays low, including across a preemption. In single-phase mode it rises on the edge where FRAME falls for the last transaction. In burst mode it rises on the edge where FRAME rises before the job's final data phase.
- R4: A transaction starts with one address cycle (FRAME low, IRDY high). A data phase completes only on an edge where IRDY, TRDY and DEVSEL are all sampled low. FRAME rises one phase before the final phase while IRDY stays low, and IRDY rises after the final phase completes. Target wait states do not change the word count.
- R5: In single-phase mode every transaction carries exactly one data phase. A transaction starts only from idle on an edge where GNT is sampled low, so a job of N makes N tenures.
- R6: In burst mode a tenure holds exactly one transaction. While the latency count is nonzero, a high GNT is ignored and the phases continue.
- R7: The latency counter loads `lat_timer` on the edge where FRAME falls, then decrements once per clock and saturates at zero. With a wait-free target and GNT high from the first data cycle, a preempted burst tenure carries max(L,1)+1 words, where L is `lat_timer`.
- R8: If DEVSEL is not sampled low on any of the 5 edges after the address phase, FRAME and IRDY are released together, `sts_mabort` is set, and the job ends with no interrupt.
- R9: STOP sampled low with DEVSEL high, after DEVSEL has been seen in that transaction, is a target abort. FRAME and IRDY are released together, `sts_tabort` and `sts_sysint` are set, and the job ends.
- R10: `int_n` is low exactly when `sts_sysint` is set and `int_en` is high. It follows `int_en` without waiting for a clock edge.
- R11: A `flag_clr` pulse clears each flag whose bit in `flag_clr_mask` is 1: bit 0 is the target-abort flag, bit 1 the master-abort flag, bit 2 the system-interrupt flag. Flags with 0 bits are left as they are.
- R12: `job_done` is a one-cycle pulse at the end of each job, whether the job completed or was aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_start | input | 1 | Job request from the DMA engine |
| job_burst | input | 1 | 1 = burst mode, 0 = single-phase train |
| job_len | input | LEN_W | Transactions (single-phase) or words (burst) |
| lat_timer | input | LAT_W | Programmed latency timer value |
| int_en | input | 1 | System-interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe |
| flag_clr_mask | input | 3 | Flags to clear (bit0 target abort, bit1 master abort, bit2 system interrupt) |
| bgnt_n | input | 1 | Bus grant, active low |
| tgt_sel_n | input | 1 | Device select from target, active low |
| tgt_rdy_n | input | 1 | Target ready, active low |
| tgt_stop_n | input | 1 | Target stop, active low |
| breq_n | output | 1 | Bus request, active low |
| frm_n | output | 1 | Cycle frame, active low |
| ird_n | output | 1 | Initiator ready, active low |
| job_busy | output | 1 | Job in progress |
| job_done | output | 1 | One-cycle end-of-job pulse |
| sts_tabort | output | 1 | Received target abort flag |
| sts_mabort | output | 1 | Master abort flag |
| sts_sysint | output | 1 | System-interrupt flag |
| int_n | output | 1 | Interrupt output, active low |

## Verification
The assertions assume the master is the only initiator on the bus. They also assume the target never asserts TRDY or STOP without first asserting DEVSEL in that transaction, except for the abort pattern, and never signals a retry or disconnect (STOP together with DEVSEL). The bench's target model asserts DEVSEL one cycle after the address cycle and drops all of its lines once FRAME and IRDY are both high. It only ever produces normal phases, wait states, silence, or a target abort after one DEVSEL cycle. The bench arbiter either follows the request line or pulls the grant as soon as FRAME falls and gives it back only when the bus is idle, so no grant ever reaches the block while another master could be driving.

// File: rtl/pcim_pkg.sv
// Package: shared types and flag indices for the PCI master sequencer.
// Assumes nothing beyond the users importing it.
package pcim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;

    localparam int FLG_N      = 3;
    localparam int FLG_TABORT = 0;
    localparam int FLG_MABORT = 1;
    localparam int FLG_SYSINT = 2;
endpackage

// File: rtl/pcim_lat_counter.sv
// Latency counter: loads on the frame-start edge, then counts down once per
// clock and holds at zero. Assumes load is a single-cycle strobe.
module pcim_lat_counter #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic [LAT_W-1:0] count,
    output logic             expired
);
    // Load, decrement, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - LAT_W'(1);
    end

    assign expired = (count == '0);
endmodule

// File: rtl/pcim_devsel_watch.sv
// Device-select watchdog: counts the data-cycle edges on which DEVSEL is
// still high and flags a timeout on the WAIT-th one. It also remembers
// whether DEVSEL was seen, which the target-abort decode needs. Assumes
// arm is high for the single address cycle of each transaction.
module pcim_devsel_watch #(
    parameter int WAIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    input  logic sel_n,
    output logic seen,
    output logic timeout
);
    localparam int CW = $clog2(WAIT + 1);

    logic [CW-1:0] miss_cnt;

    // Track DEVSEL arrival and the count of missed samples.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            seen     <= 1'b0;
            miss_cnt <= '0;
        end else if (active && !seen) begin
            if (!sel_n)
                seen <= 1'b1;
            else if (miss_cnt != CW'(WAIT - 1))
                miss_cnt <= miss_cnt + CW'(1);
        end
    end

    assign timeout = active && !seen && sel_n && (miss_cnt == CW'(WAIT - 1));
endmodule

// File: rtl/pcim_flags.sv
// Status flags with write-one-to-clear and the masked interrupt output.
// A set and a clear of the same flag in one cycle leave the flag set.
module pcim_flags
    import pcim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLG_N-1:0] set_vec,
    input  logic             clr,
    input  logic [FLG_N-1:0] clr_mask,
    input  logic             int_en,
    output logic [FLG_N-1:0] flags,
    output logic             int_n
);
    logic [FLG_N-1:0] clr_vec;

    // Select which flags the host clear strobe removes.
    always_comb clr_vec = clr ? clr_mask : '0;

    // Update flags: clear requested bits, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_vec) | set_vec;
    end

    assign int_n = !(flags[FLG_SYSINT] && int_en);
endmodule

// File: rtl/pcim_preempt_seq.sv
// PCI bus master preemption sequencer (top). It runs one DMA job at a time
// in single-phase or burst mode, drives REQ/FRAME/IRDY from registers and
// samples GNT/DEVSEL/TRDY/STOP. Assumes it is the only initiator, that the
// target never signals retry or disconnect, and that job_len is nonzero.
module pcim_preempt_seq
    import pcim_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int LAT_W       = 8,
    parameter int DEVSEL_WAIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             job_start,
    input  logic             job_burst,
    input  logic [LEN_W-1:0] job_len,
    input  logic [LAT_W-1:0] lat_timer,
    input  logic             int_en,
    input  logic             flag_clr,
    input  logic [2:0]       flag_clr_mask,
    input  logic             bgnt_n,
    input  logic             tgt_sel_n,
    input  logic             tgt_rdy_n,
    input  logic             tgt_stop_n,
    output logic             breq_n,
    output logic             frm_n,
    output logic             ird_n,
    output logic             job_busy,
    output logic             job_done,
    output logic             sts_tabort,
    output logic             sts_mabort,
    output logic             sts_sysint,
    output logic             int_n
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    seq_state_t       state;
    logic             burst_q, busy_q, done_q;
    logic             frm_q, ird_q, req_q;
    logic [LEN_W-1:0] rem_q;
    logic [LAT_W-1:0] lat_cnt;
    logic             lat_exp, lat_load;
    logic             sel_seen, sel_timeout;
    logic             xfer, tabort, abort_any, preempt;
    logic [FLG_N-1:0] flag_set, flag_q;

    // The frame-start edge loads the latency counter.
    assign lat_load = (state == ST_IDLE) && busy_q && !bgnt_n;

    pcim_lat_counter #(.LAT_W(LAT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (lat_timer),
        .count    (lat_cnt),
        .expired  (lat_exp)
    );

    pcim_devsel_watch #(.WAIT(DEVSEL_WAIT)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state == ST_ADDR),
        .active  (state == ST_DATA),
        .sel_n   (tgt_sel_n),
        .seen    (sel_seen),
        .timeout (sel_timeout)
    );

    // Decode the bus events sampled at this edge.
    always_comb begin
        xfer      = (state == ST_DATA) && !ird_q && !tgt_rdy_n && !tgt_sel_n;
        tabort    = (state == ST_DATA) && sel_seen && !tgt_stop_n && tgt_sel_n;
        abort_any = tabort || sel_timeout;
        preempt   = bgnt_n && lat_exp;
        flag_set             = '0;
        flag_set[FLG_TABORT] = tabort;
        flag_set[FLG_SYSINT] = tabort;
        flag_set[FLG_MABORT] = sel_timeout;
    end

    pcim_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (flag_set),
        .clr      (flag_clr),
        .clr_mask (flag_clr_mask),
        .int_en   (int_en),
        .flags    (flag_q),
        .int_n    (int_n)
    );

    // Main sequencer: job intake, phase control and request policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            burst_q <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            frm_q   <= 1'b1;
            ird_q   <= 1'b1;
            req_q   <= 1'b1;
            rem_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (!busy_q) begin
                        if (job_start && job_len != '0) begin
                            busy_q  <= 1'b1;
                            burst_q <= job_burst;
                            rem_q   <= job_len;
                            req_q   <= 1'b0;
                        end
                    end else if (!bgnt_n) begin
                        state <= ST_ADDR;
                        frm_q <= 1'b0;
                        if (!burst_q && rem_q == ONE)
                            req_q <= 1'b1;
                    end
                end
                ST_ADDR: begin
                    state <= ST_DATA;
                    ird_q <= 1'b0;
                    if (!burst_q || rem_q == ONE) begin
                        frm_q <= 1'b1;
                        if (rem_q == ONE)
                            req_q <= 1'b1;
                    end
                end
                ST_DATA: begin
                    if (abort_any) begin
                        state  <= ST_IDLE;
                        frm_q  <= 1'b1;
                        ird_q  <= 1'b1;
                        req_q  <= 1'b1;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        rem_q  <= '0;
                    end else if (xfer) begin
                        rem_q <= rem_q - ONE;
                        if (frm_q) begin
                            state <= ST_IDLE;
                            ird_q <= 1'b1;
                            if (rem_q == ONE) begin
                                busy_q <= 1'b0;
                                done_q <= 1'b1;
                            end
                        end else if (rem_q == TWO || preempt) begin
                            frm_q <= 1'b1;
                            if (rem_q == TWO)
                                req_q <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign breq_n     = req_q;
    assign frm_n      = frm_q;
    assign ird_n      = ird_q;
    assign job_busy   = busy_q;
    assign job_done   = done_q;
    assign sts_tabort = flag_q[FLG_TABORT];
    assign sts_mabort = flag_q[FLG_MABORT];
    assign sts_sysint = flag_q[FLG_SYSINT];
endmodule

// File: rtl/pcim_preempt_seq_chk.sv
// Checker for the PCI master sequencer, bound to every instance of the top.
// Assumes the bus conditions stated in the brief's verification section.
module pcim_preempt_seq_chk #(
    parameter int LEN_W = 8,
    parameter int LAT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_n,
    input logic             ird_n,
    input logic             breq_n,
    input logic             tgt_sel_n,
    input logic             tgt_rdy_n,
    input logic             tgt_stop_n,
    input logic             int_en,
    input logic             int_n,
    input logic             sts_tabort,
    input logic             sts_mabort,
    input logic             sts_sysint,
    input logic             job_busy,
    input logic             job_done,
    input logic             burst_q,
    input logic [LEN_W-1:0] rem_q,
    input logic [LAT_W-1:0] lat_cnt,
    input logic             lat_load,
    input logic             sel_seen
);
    // R4: the address cycle has IRDY deasserted.
    a_r4_addr_irdy_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_n) |-> ird_n);

    // R4: IRDY is released once the final phase completes.
    a_r4_final_release: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_n && !ird_n && !tgt_rdy_n && !tgt_sel_n) |=> ird_n);

    // R3: the request stays asserted while more than one item remains.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (job_busy && rem_q > LEN_W'(1)) |-> !breq_n);

    // R6: a burst continues past a completed phase while latency remains.
    a_r6_gnt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q && !frm_n && !ird_n && !tgt_rdy_n && !tgt_sel_n &&
         rem_q > LEN_W'(2) && lat_cnt != '0) |=> !frm_n);

    // R7: the latency count holds at zero until the next load.
    a_r7_lat_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == '0 && !lat_load) |=> lat_cnt == '0);

    // R8: a master abort leaves the bus released.
    a_r8_mabort_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_mabort) |-> (frm_n && ird_n));

    // R9: a target abort sets both flags and releases the bus.
    a_r9_tabort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!ird_n && sel_seen && !tgt_stop_n && tgt_sel_n) |=>
        (sts_tabort && sts_sysint && frm_n && ird_n));

    // R10: with the enable low the interrupt stays deasserted.
    a_r10_int_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> int_n);

    // R12: the end-of-job strobe lasts one cycle.
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> !job_done);
endmodule

bind pcim_preempt_seq pcim_preempt_seq_chk #(.LEN_W(LEN_W), .LAT_W(LAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_n      (frm_n),
    .ird_n      (ird_n),
    .breq_n     (breq_n),
    .tgt_sel_n  (tgt_sel_n),
    .tgt_rdy_n  (tgt_rdy_n),
    .tgt_stop_n (tgt_stop_n),
    .int_en     (int_en),
    .int_n      (int_n),
    .sts_tabort (sts_tabort),
    .sts_mabort (sts_mabort),
    .sts_sysint (sts_sysint),
    .job_busy   (job_busy),
    .job_done   (job_done),
    .burst_q    (burst_q),
    .rem_q      (rem_q),
    .lat_cnt    (lat_cnt),
    .lat_load   (lat_load),
    .sel_seen   (sel_seen)
);

// File: tb/pcim_preempt_seq_tb.sv
// Directed bench: models the arbiter and the target, and records per-tenure
// word counts and request levels.
module pcim_preempt_seq_tb;
    localparam int LEN_W = 8;
    localparam int LAT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic job_start = 1'b0, job_burst = 1'b0;
    logic [LEN_W-1:0] job_len = '0;
    logic [LAT_W-1:0] lat_timer = '0;
    logic int_en = 1'b0, flag_clr = 1'b0;
    logic [2:0] flag_clr_mask = 3'b000;
    logic bgnt_n, tgt_sel_n, tgt_rdy_n, tgt_stop_n;
    logic breq_n, frm_n, ird_n, job_busy, job_done;
    logic sts_tabort, sts_mabort, sts_sysint, int_n;

    int nchk = 0, nerr = 0;
    int arb_mode = 0;   // 0: grant follows request, 1: pull grant on FRAME
    int tgt_mode = 0;   // 0 normal, 1 waits, 2 silent, 3 target abort
    int tw[16], trs[16], tre[16];
    int ntn = 0, ndone = 0, mon_on = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pcim_preempt_seq #(.LEN_W(LEN_W), .LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_burst(job_burst),
        .job_len(job_len), .lat_timer(lat_timer), .int_en(int_en),
        .flag_clr(flag_clr), .flag_clr_mask(flag_clr_mask), .bgnt_n(bgnt_n),
        .tgt_sel_n(tgt_sel_n), .tgt_rdy_n(tgt_rdy_n), .tgt_stop_n(tgt_stop_n),
        .breq_n(breq_n), .frm_n(frm_n), .ird_n(ird_n), .job_busy(job_busy),
        .job_done(job_done), .sts_tabort(sts_tabort), .sts_mabort(sts_mabort),
        .sts_sysint(sts_sysint), .int_n(int_n)
    );

    // Arbiter and target models, driven at the falling edge.
    bit tseen;
    int tcyc;
    always @(negedge clk) begin
        if (!rst_n) begin
            bgnt_n = 1'b1; tgt_sel_n = 1'b1; tgt_rdy_n = 1'b1; tgt_stop_n = 1'b1;
            tseen = 1'b0; tcyc = 0;
        end else begin
            if (arb_mode == 0) bgnt_n = breq_n;
            else if (!frm_n) bgnt_n = 1'b1;
            else if (ird_n && !breq_n) bgnt_n = 1'b0;
            else if (breq_n) bgnt_n = 1'b1;
            if (frm_n && ird_n) begin
                tgt_sel_n = 1'b1; tgt_rdy_n = 1'b1; tgt_stop_n = 1'b1;
                tseen = 1'b0; tcyc = 0;
            end else if (!tseen) begin
                tseen = 1'b1;
            end else begin
                tcyc++;
                case (tgt_mode)
                    0: begin tgt_sel_n = 1'b0; tgt_rdy_n = 1'b0; end
                    1: begin tgt_sel_n = 1'b0; tgt_rdy_n = tcyc[0]; end
                    3: begin
                        if (tcyc == 1) begin tgt_sel_n = 1'b0; tgt_rdy_n = 1'b1; end
                        else begin tgt_sel_n = 1'b1; tgt_stop_n = 1'b0; end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Monitor: samples between edges; counts words, tenures and done pulses.
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (job_done) ndone++;
            if (!mon_on && !frm_n) begin
                mon_on = 1;
                if (ntn < 16) begin tw[ntn] = 0; trs[ntn] = int'(breq_n); end
                ntn++;
            end
            if (mon_on) begin
                if (!ird_n && !tgt_rdy_n && !tgt_sel_n && ntn <= 16) tw[ntn-1]++;
                if (frm_n && ird_n) begin
                    mon_on = 0;
                    if (ntn <= 16) tre[ntn-1] = int'(breq_n);
                end
            end
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic run_job(input bit burst, input int len, input int lat, input int arb,
                           input int tgt);
        int d0;
        arb_mode = arb; tgt_mode = tgt;
        ntn = 0; mon_on = 0;
        for (int i = 0; i < 16; i++) begin tw[i] = 0; trs[i] = 0; tre[i] = 0; end
        d0 = ndone;
        @(negedge clk);
        job_burst = burst; job_len = LEN_W'(len); lat_timer = LAT_W'(lat);
        job_start = 1'b1;
        @(negedge clk);
        job_start = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #3;
            if (ndone > d0) break;
        end
        chk("R12 job ended", int'(ndone > d0), 1);
        repeat (4) @(negedge clk);
        chk("R12 single done pulse", ndone - d0, 1);
    endtask

    task automatic t_reset;
        @(negedge clk); #2;
        chk("R1 breq_n", int'(breq_n), 1);
        chk("R1 frm_n", int'(frm_n), 1);
        chk("R1 ird_n", int'(ird_n), 1);
        chk("R1 int_n", int'(int_n), 1);
        chk("R1 job_busy", int'(job_busy), 0);
        chk("R1 flags", int'({sts_tabort, sts_mabort, sts_sysint}), 0);
    endtask

    task automatic t_single_hold;
        run_job(1'b0, 3, 0, 0, 0);
        chk("R5 tenures", ntn, 3);
        for (int i = 0; i < 3; i++) chk("R5 one phase each", tw[i], 1);
        chk("R3 req low at 1st frame", trs[0], 0);
        chk("R3 req low at 2nd frame", trs[1], 0);
        chk("R3 req high at last frame", trs[2], 1);
    endtask

    task automatic t_single_preempt;
        run_job(1'b0, 3, 0, 1, 0);
        chk("R5 tenures preempt", ntn, 3);
        for (int i = 0; i < 3; i++) chk("R5 one phase preempt", tw[i], 1);
        chk("R3 req kept after 1st", tre[0], 0);
        chk("R3 req kept after 2nd", tre[1], 0);
        chk("R3 req released at end", tre[2], 1);
    endtask

    task automatic t_burst_ignore;
        run_job(1'b1, 6, 20, 1, 0);
        chk("R6 one tenure", ntn, 1);
        chk("R6 all words despite GNT high", tw[0], 6);
    endtask

    task automatic t_burst_waits;
        run_job(1'b1, 4, 0, 0, 1);
        chk("R4 tenures with waits", ntn, 1);
        chk("R4 words with waits", tw[0], 4);
    endtask

    task automatic t_burst_lat(input int lat, input int len, input int e0, input int e1,
                               input int e2);
        run_job(1'b1, len, lat, 1, 0);
        chk("R7 tenure count", ntn, 3);
        chk("R7 tenure 1 words", tw[0], e0);
        chk("R7 tenure 2 words", tw[1], e1);
        chk("R7 tenure 3 words", tw[2], e2);
        chk("R3 req kept after preempt", tre[0] + tre[1], 0);
        chk("R3 req released at job end", tre[2], 1);
    endtask

    task automatic t_busy_ignore;
        int d0;
        arb_mode = 1; tgt_mode = 0;
        ntn = 0; mon_on = 0;
        for (int i = 0; i < 16; i++) tw[i] = 0;
        d0 = ndone;
        @(negedge clk);
        job_burst = 1'b1; job_len = LEN_W'(4); lat_timer = LAT_W'(20); job_start = 1'b1;
        @(negedge clk); job_start = 1'b0;
        repeat (3) @(negedge clk);
        job_len = LEN_W'(9); job_burst = 1'b0; job_start = 1'b1;
        @(negedge clk); job_start = 1'b0;
        repeat (60) @(negedge clk);
        chk("R2 words of first job only", tw[0] + tw[1], 4);
        chk("R2 tenures", ntn, 1);
        chk("R2 one done", ndone - d0, 1);
        chk("R2 idle after", int'(job_busy), 0);
    endtask

    task automatic clear_flags(input logic [2:0] m);
        @(negedge clk); flag_clr = 1'b1; flag_clr_mask = m;
        @(negedge clk); flag_clr = 1'b0; flag_clr_mask = 3'b000; #2;
    endtask

    task automatic t_mabort;
        int_en = 1'b1;
        run_job(1'b0, 2, 0, 0, 2);
        chk("R8 no words", tw[0], 0);
        chk("R8 one tenure then end", ntn, 1);
        chk("R8 mabort flag", int'(sts_mabort), 1);
        chk("R8 no tabort", int'(sts_tabort), 0);
        chk("R8 no interrupt", int'(int_n), 1);
        chk("R8 request dropped", int'(breq_n), 1);
        clear_flags(3'b010);
        chk("R11 mabort cleared", int'(sts_mabort), 0);
    endtask

    task automatic t_tabort;
        int_en = 1'b1;
        run_job(1'b1, 4, 0, 0, 3);
        chk("R9 no words", tw[0], 0);
        chk("R9 tabort flag", int'(sts_tabort), 1);
        chk("R9 sysint flag", int'(sts_sysint), 1);
        chk("R9 mabort untouched", int'(sts_mabort), 0);
        chk("R10 int asserted", int'(int_n), 0);
        int_en = 1'b0; #1;
        chk("R10 int masked", int'(int_n), 1);
        int_en = 1'b1; #1;
        chk("R10 int unmasked", int'(int_n), 0);
        clear_flags(3'b001);
        chk("R11 tabort cleared", int'(sts_tabort), 0);
        chk("R11 sysint kept", int'(sts_sysint), 1);
        chk("R11 int still low", int'(int_n), 0);
        clear_flags(3'b100);
        chk("R11 sysint cleared", int'(sts_sysint), 0);
        chk("R10 int released", int'(int_n), 1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_single_hold;
        t_single_preempt;
        t_burst_ignore;
        t_burst_waits;
        t_burst_lat(2, 8, 3, 3, 2);
        t_burst_lat(0, 5, 2, 2, 1);
        t_busy_ignore;
        t_mabort;
        t_tabort;
        finish_run;
    end

    initial begin
        #(8 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run;
    end
endmodule